// File: doc/BRIEF.md
# Switch Connection Hold and Release Tracker

This block holds the switch connection state of every output port in a router that reuses a departing packet's crossbar path for a waiting packet bound to the same output. For each output it keeps whether a connection exists, which input port and input virtual channel (VC) feed it, which output VC it is using, and how many cycles it has been held. Every cycle it decides, for each output, whether the connection is kept, replaced by a fresh switch grant, handed over to a chained packet, or torn down.

A connection is torn down for any of four reasons: the output VC it uses has run out of credits, the input VC feeding it has gone empty, a higher-priority request is aimed at that output, or it has been held for the programmed hold limit (even in the middle of a packet). One cycle before the hold limit is reached the output raises a near-limit flag, and from then on chaining grants for that output are refused, so the switch allocator can hand the ports to waiting packets. Age-based release can be switched off at run time.

The surrounding allocators drive switch grants and chaining grants per output; the crossbar datapath reads the connection map.

Top module: `conn_tracker`

## Requirements
- R1: While reset is asserted and right after it, no output reports a connection, a release pulse or a near-limit flag.
- R2: A switch grant on an output (sw_vld bit set) creates a connection visible from the next cycle, carrying the granted input, input VC and output VC, with its hold count starting at 1; a switch grant always overrides a chaining grant on that output.
- R3: A held connection whose output VC has a credit count of zero raises its release pulse in that cycle and is gone in the next; zero credits on any other output VC of that output have no effect.
- R4: A held connection whose input VC is flagged empty (ivc_empty bit input*NUM_VC+vc) is released the same way; an empty flag on another input VC has no effect.
- R5: A priority request on a connected output releases its connection the same way.
- R6: With age release enabled and hold limit L, a connection left undisturbed is visible for exactly L cycles and raises its release pulse in the L-th; this holds for L=8 (default) and L=4.
- R7: The near-limit flag is high exactly in the cycle where the hold count equals L-1; a chaining grant in that cycle is refused and the connection keeps its source.
- R8: An accepted chaining grant from a different input or input VC replaces the source and output VC and restarts the hold count at 1; one from the same input and input VC keeps counting.
- R9: A chaining grant whose input also receives a switch grant on any output in the same cycle is disregarded.
- R10: When a release cause and a new grant for the same output coincide, the new grant wins: no release pulse, and the new connection appears.
- R11: With age release disabled, connections are never released for age and the near-limit flag stays low.
- R12: A chaining grant on an output with no connection is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_limit | input | AGE_W | Maximum hold cycles L (at least 2) |
| starve_off | input | 1 | 1 disables release for age |
| sw_vld | input | NUM_OUT | Switch grant per output |
| sw_in | input | NUM_OUT*IN_W | Granted input, field o at o*IN_W |
| sw_ivc | input | NUM_OUT*VC_W | Granted input VC per output |
| sw_ovc | input | NUM_OUT*VC_W | Granted output VC per output |
| ch_vld | input | NUM_OUT | Chaining grant per output |
| ch_in | input | NUM_OUT*IN_W | Chained input per output |
| ch_ivc | input | NUM_OUT*VC_W | Chained input VC per output |
| ch_ovc | input | NUM_OUT*VC_W | Output VC for chained packet |
| out_credit | input | NUM_OUT*NUM_VC*CRED_W | Credit count, field (o*NUM_VC+v)*CRED_W |
| ivc_empty | input | NUM_IN*NUM_VC | Empty flag, bit i*NUM_VC+v |
| prio_req | input | NUM_OUT | Higher-priority request per output |
| conn_vld | output | NUM_OUT | Connection held per output |
| conn_in | output | NUM_OUT*IN_W | Connected input per output |
| conn_ivc | output | NUM_OUT*VC_W | Connected input VC per output |
| conn_ovc | output | NUM_OUT*VC_W | Output VC in use per output |
| rel_pulse | output | NUM_OUT | Connection torn down this cycle |
| near_starve | output | NUM_OUT | Hold count one short of the limit |

## Verification
The bound checker watches, on every cycle and every output, that a switch grant always yields a connection with the granted input, that a release pulse is always followed by an empty slot, that a priority request on an uncontested connection always releases it, that a fresh grant suppresses the release pulse, and that the near-limit flag never appears without a connection or with age release off. The exact hold duration for several limits, the restart or continuation of the count under chaining, refusal of chaining at the near-limit cycle, and the cross-output input conflict need ordered sequences and are shown only by the bench's scenarios.

// File: rtl/conn_pkg.sv
package conn_pkg;

  // Per-output decision taken each cycle
  typedef enum logic [2:0] {
    ACT_IDLE,   // no connection, nothing arrives
    ACT_KEEP,   // connection held, hold count advances
    ACT_OPEN,   // switch grant builds a new connection
    ACT_CHAIN,  // accepted chaining grant takes the connection over
    ACT_DROP    // a release cause tears the connection down
  } slot_act_e;

endpackage

// File: rtl/chain_filter.sv
// Flags chaining grants whose input is also taken by a switch grant.
module chain_filter #(
  parameter int NUM_OUT = 5,
  parameter int IN_W    = 3
) (
  input  logic [NUM_OUT-1:0]      sw_vld,
  input  logic [NUM_OUT*IN_W-1:0] sw_in,
  input  logic [NUM_OUT*IN_W-1:0] ch_in,
  output logic [NUM_OUT-1:0]      ch_block
);

  always_comb begin
    ch_block = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      for (int p = 0; p < NUM_OUT; p++) begin
        if (sw_vld[p] && (sw_in[p*IN_W +: IN_W] == ch_in[o*IN_W +: IN_W])) begin
          ch_block[o] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/conn_slot.sv
// Connection state and hold/release decision for one output port.
module conn_slot
  import conn_pkg::*;
#(
  parameter int NUM_IN = 5,
  parameter int NUM_VC = 4,
  parameter int CRED_W = 4,
  parameter int AGE_W  = 4,
  parameter int IN_W   = 3,
  parameter int VC_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AGE_W-1:0]           hold_limit,
  input  logic                       starve_off,
  input  logic                       sw_vld,
  input  logic [IN_W-1:0]            sw_in,
  input  logic [VC_W-1:0]            sw_ivc,
  input  logic [VC_W-1:0]            sw_ovc,
  input  logic                       ch_vld,
  input  logic                       ch_block,
  input  logic [IN_W-1:0]            ch_in,
  input  logic [VC_W-1:0]            ch_ivc,
  input  logic [VC_W-1:0]            ch_ovc,
  input  logic [NUM_VC*CRED_W-1:0]   credits,
  input  logic [NUM_IN*NUM_VC-1:0]   ivc_empty,
  input  logic                       prio,
  output logic                       vld,
  output logic [IN_W-1:0]            in_o,
  output logic [VC_W-1:0]            ivc_o,
  output logic [VC_W-1:0]            ovc_o,
  output logic                       rel,
  output logic                       near
);

  slot_act_e        act;
  logic             vld_q, vld_d;
  logic [IN_W-1:0]  in_q, in_d;
  logic [VC_W-1:0]  ivc_q, ivc_d;
  logic [VC_W-1:0]  ovc_q, ovc_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic [AGE_W:0]   age_nxt;
  logic [CRED_W-1:0] cred_sel;
  logic             empty_sel;
  logic             age_hit, inelig, cause, ch_take, same_src, en;

  // credit count of the output VC in use
  always_comb begin
    cred_sel = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (ovc_q == VC_W'(v)) cred_sel = credits[v*CRED_W +: CRED_W];
    end
  end

  // empty flag of the input VC feeding the connection
  always_comb begin
    empty_sel = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      for (int v = 0; v < NUM_VC; v++) begin
        if ((in_q == IN_W'(i)) && (ivc_q == VC_W'(v))) empty_sel = ivc_empty[i*NUM_VC + v];
      end
    end
  end

  assign age_nxt  = {1'b0, age_q} + 1'b1;
  assign age_hit  = !starve_off && (age_q >= hold_limit);
  assign inelig   = !starve_off && (age_nxt >= {1'b0, hold_limit});
  assign near     = vld_q && !starve_off && (age_nxt == {1'b0, hold_limit});
  assign cause    = vld_q && ((cred_sel == '0) || empty_sel || prio || age_hit);
  assign ch_take  = ch_vld && !ch_block && !sw_vld && vld_q && !inelig;
  assign same_src = (ch_in == in_q) && (ch_ivc == ivc_q);

  always_comb begin
    if (sw_vld)       act = ACT_OPEN;
    else if (ch_take) act = ACT_CHAIN;
    else if (cause)   act = ACT_DROP;
    else if (vld_q)   act = ACT_KEEP;
    else              act = ACT_IDLE;
  end

  assign rel = (act == ACT_DROP);
  assign en  = (act != ACT_IDLE);

  always_comb begin
    vld_d = vld_q;
    in_d  = in_q;
    ivc_d = ivc_q;
    ovc_d = ovc_q;
    age_d = age_q;
    case (act)
      ACT_OPEN: begin
        vld_d = 1'b1;
        in_d  = sw_in;
        ivc_d = sw_ivc;
        ovc_d = sw_ovc;
        age_d = AGE_W'(1);
      end
      ACT_CHAIN: begin
        vld_d = 1'b1;
        in_d  = ch_in;
        ivc_d = ch_ivc;
        ovc_d = ch_ovc;
        age_d = same_src ? age_nxt[AGE_W-1:0] : AGE_W'(1);
      end
      ACT_DROP: begin
        vld_d = 1'b0;
        age_d = '0;
      end
      ACT_KEEP: begin
        age_d = (age_q == '1) ? age_q : age_nxt[AGE_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      in_q  <= '0;
      ivc_q <= '0;
      ovc_q <= '0;
      age_q <= '0;
    end else if (en) begin
      vld_q <= vld_d;
      in_q  <= in_d;
      ivc_q <= ivc_d;
      ovc_q <= ovc_d;
      age_q <= age_d;
    end
  end

  assign vld   = vld_q;
  assign in_o  = in_q;
  assign ivc_o = ivc_q;
  assign ovc_o = ovc_q;

endmodule

// File: rtl/conn_tracker.sv
// Per-output connection hold/release tracker for a chaining router.
module conn_tracker #(
  parameter int NUM_OUT  = 5,
  parameter int NUM_IN   = 5,
  parameter int NUM_VC   = 4,
  parameter int BUF_DEP  = 8,
  parameter int MAX_HOLD = 15,
  localparam int IN_W   = $clog2(NUM_IN),
  localparam int VC_W   = $clog2(NUM_VC),
  localparam int CRED_W = $clog2(BUF_DEP + 1),
  localparam int AGE_W  = $clog2(MAX_HOLD + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [AGE_W-1:0]                  hold_limit,
  input  logic                              starve_off,
  input  logic [NUM_OUT-1:0]                sw_vld,
  input  logic [NUM_OUT*IN_W-1:0]           sw_in,
  input  logic [NUM_OUT*VC_W-1:0]           sw_ivc,
  input  logic [NUM_OUT*VC_W-1:0]           sw_ovc,
  input  logic [NUM_OUT-1:0]                ch_vld,
  input  logic [NUM_OUT*IN_W-1:0]           ch_in,
  input  logic [NUM_OUT*VC_W-1:0]           ch_ivc,
  input  logic [NUM_OUT*VC_W-1:0]           ch_ovc,
  input  logic [NUM_OUT*NUM_VC*CRED_W-1:0]  out_credit,
  input  logic [NUM_IN*NUM_VC-1:0]          ivc_empty,
  input  logic [NUM_OUT-1:0]                prio_req,
  output logic [NUM_OUT-1:0]                conn_vld,
  output logic [NUM_OUT*IN_W-1:0]           conn_in,
  output logic [NUM_OUT*VC_W-1:0]           conn_ivc,
  output logic [NUM_OUT*VC_W-1:0]           conn_ovc,
  output logic [NUM_OUT-1:0]                rel_pulse,
  output logic [NUM_OUT-1:0]                near_starve
);

  logic [NUM_OUT-1:0] ch_block;

  chain_filter #(
    .NUM_OUT (NUM_OUT),
    .IN_W    (IN_W)
  ) u_filter (
    .sw_vld   (sw_vld),
    .sw_in    (sw_in),
    .ch_in    (ch_in),
    .ch_block (ch_block)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    conn_slot #(
      .NUM_IN (NUM_IN),
      .NUM_VC (NUM_VC),
      .CRED_W (CRED_W),
      .AGE_W  (AGE_W),
      .IN_W   (IN_W),
      .VC_W   (VC_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_limit (hold_limit),
      .starve_off (starve_off),
      .sw_vld     (sw_vld[o]),
      .sw_in      (sw_in[o*IN_W +: IN_W]),
      .sw_ivc     (sw_ivc[o*VC_W +: VC_W]),
      .sw_ovc     (sw_ovc[o*VC_W +: VC_W]),
      .ch_vld     (ch_vld[o]),
      .ch_block   (ch_block[o]),
      .ch_in      (ch_in[o*IN_W +: IN_W]),
      .ch_ivc     (ch_ivc[o*VC_W +: VC_W]),
      .ch_ovc     (ch_ovc[o*VC_W +: VC_W]),
      .credits    (out_credit[o*NUM_VC*CRED_W +: NUM_VC*CRED_W]),
      .ivc_empty  (ivc_empty),
      .prio       (prio_req[o]),
      .vld        (conn_vld[o]),
      .in_o       (conn_in[o*IN_W +: IN_W]),
      .ivc_o      (conn_ivc[o*VC_W +: VC_W]),
      .ovc_o      (conn_ovc[o*VC_W +: VC_W]),
      .rel        (rel_pulse[o]),
      .near       (near_starve[o])
    );
  end

endmodule

// File: rtl/conn_tracker_chk.sv
module conn_tracker_chk #(
  parameter int NUM_OUT = 5,
  parameter int IN_W    = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      starve_off,
  input logic [NUM_OUT-1:0]        sw_vld,
  input logic [NUM_OUT*IN_W-1:0]   sw_in,
  input logic [NUM_OUT-1:0]        ch_vld,
  input logic [NUM_OUT-1:0]        prio_req,
  input logic [NUM_OUT-1:0]        conn_vld,
  input logic [NUM_OUT*IN_W-1:0]   conn_in,
  input logic [NUM_OUT-1:0]        rel_pulse,
  input logic [NUM_OUT-1:0]        near_starve
);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    // R2
    sw_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_vld[o] |=> (conn_vld[o] && (conn_in[o*IN_W +: IN_W] == $past(sw_in[o*IN_W +: IN_W]))));
    // R3
    rel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_pulse[o] |=> !conn_vld[o]);
    // R5
    prio_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_req[o] && conn_vld[o] && !sw_vld[o] && !ch_vld[o]) |-> rel_pulse[o]);
    // R7
    near_needs_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      near_starve[o] |-> conn_vld[o]);
    // R10
    grant_beats_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_vld[o] |-> !rel_pulse[o]);
    // R11
    no_near_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      starve_off |-> !near_starve[o]);
  end

endmodule

bind conn_tracker conn_tracker_chk #(
  .NUM_OUT (NUM_OUT),
  .IN_W    (IN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .starve_off  (starve_off),
  .sw_vld      (sw_vld),
  .sw_in       (sw_in),
  .ch_vld      (ch_vld),
  .prio_req    (prio_req),
  .conn_vld    (conn_vld),
  .conn_in     (conn_in),
  .rel_pulse   (rel_pulse),
  .near_starve (near_starve)
);

// File: tb/conn_tracker_tb.sv
module conn_tracker_tb;
  localparam int NO = 5, NI = 5, NV = 4, CRW = 4, AW = 4, IW = 3, VW = 2;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [AW-1:0]       hold_limit;
  logic                starve_off;
  logic [NO-1:0]       sw_vld, ch_vld, prio_req;
  logic [NO*IW-1:0]    sw_in, ch_in;
  logic [NO*VW-1:0]    sw_ivc, sw_ovc, ch_ivc, ch_ovc;
  logic [NO*NV*CRW-1:0] out_credit;
  logic [NI*NV-1:0]    ivc_empty;
  logic [NO-1:0]       conn_vld, rel_pulse, near_starve;
  logic [NO*IW-1:0]    conn_in;
  logic [NO*VW-1:0]    conn_ivc, conn_ovc;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  conn_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .hold_limit(hold_limit), .starve_off(starve_off),
    .sw_vld(sw_vld), .sw_in(sw_in), .sw_ivc(sw_ivc), .sw_ovc(sw_ovc),
    .ch_vld(ch_vld), .ch_in(ch_in), .ch_ivc(ch_ivc), .ch_ovc(ch_ovc),
    .out_credit(out_credit), .ivc_empty(ivc_empty), .prio_req(prio_req),
    .conn_vld(conn_vld), .conn_in(conn_in), .conn_ivc(conn_ivc), .conn_ovc(conn_ovc),
    .rel_pulse(rel_pulse), .near_starve(near_starve)
  );

  // op[11:10] (0 idle,1 switch grant,2 chain grant,3 priority), src[9:7], ivc[6:5],
  // expected release[4], expected valid after edge[3], expected input after edge[2:0]
  localparam logic [11:0] TBL [7] = '{
    {2'd1, 3'd1, 2'd2, 1'b0, 1'b1, 3'd1},  // R2 open
    {2'd0, 3'd0, 2'd0, 1'b0, 1'b1, 3'd1},  // hold
    {2'd2, 3'd1, 2'd2, 1'b0, 1'b1, 3'd1},  // R8 same source chain
    {2'd2, 3'd3, 2'd0, 1'b0, 1'b1, 3'd3},  // R8 other source chain
    {2'd3, 3'd0, 2'd0, 1'b1, 1'b0, 3'd0},  // R5 priority release
    {2'd2, 3'd2, 2'd1, 1'b0, 1'b0, 3'd0},  // R12 chain with no connection
    {2'd1, 3'd4, 2'd1, 1'b0, 1'b1, 3'd4}   // R2 reopen
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    sw_vld = '0; sw_in = '0; sw_ivc = '0; sw_ovc = '0;
    ch_vld = '0; ch_in = '0; ch_ivc = '0; ch_ovc = '0;
    prio_req = '0; ivc_empty = '0;
    out_credit = {NO*NV{4'd3}};
  endtask

  task automatic sw(input int o, input int src, input int vc);
    sw_vld[o] = 1'b1;
    sw_in[o*IW +: IW] = IW'(src);
    sw_ivc[o*VW +: VW] = VW'(vc);
    sw_ovc[o*VW +: VW] = 2'd1;
  endtask

  task automatic ch(input int o, input int src, input int vc);
    ch_vld[o] = 1'b1;
    ch_in[o*IW +: IW] = IW'(src);
    ch_ivc[o*VW +: VW] = VW'(vc);
    ch_ovc[o*VW +: VW] = 2'd1;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    tick();
    check("R1 valid in reset", 32'(conn_vld), 0);
    check("R1 release in reset", 32'(rel_pulse), 0);
    check("R1 near in reset", 32'(near_starve), 0);
    rst_n = 1'b1;
    tick();
    check("R1 valid after reset", 32'(conn_vld), 0);
  endtask

  // walks hold counts k = first..L with no disturbance; output o is already held
  task automatic age_run(input int o, input int lim, input int first, input string tag);
    for (int k = first; k <= lim; k++) begin
      idle();
      #1;
      check({tag, " near"}, 32'(near_starve[o]), 32'(k == lim - 1));
      check({tag, " release"}, 32'(rel_pulse[o]), 32'(k == lim));
      tick();
      check({tag, " valid"}, 32'(conn_vld[o]), 32'(k < lim));
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    hold_limit = 4'd8;
    starve_off = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (3) tick();
    // R1
    check("R1 valid", 32'(conn_vld), 0);
    check("R1 release", 32'(rel_pulse), 0);
    check("R1 near", 32'(near_starve), 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 7; i++) begin
      idle();
      case (TBL[i][11:10])
        2'd1: sw(0, int'(TBL[i][9:7]), int'(TBL[i][6:5]));
        2'd2: ch(0, int'(TBL[i][9:7]), int'(TBL[i][6:5]));
        2'd3: prio_req[0] = 1'b1;
        default: ;
      endcase
      #1;
      check($sformatf("R2/R5/R8/R12 table %0d release", i), 32'(rel_pulse[0]), 32'(TBL[i][4]));
      tick();
      check($sformatf("R2/R5/R8/R12 table %0d valid", i), 32'(conn_vld[0]), 32'(TBL[i][3]));
      if (TBL[i][3])
        check($sformatf("R2/R8 table %0d input", i), 32'(conn_in[0 +: IW]), 32'(TBL[i][2:0]));
    end

    // R3: credits on another output VC, then on the one in use
    do_reset();
    sw(0, 1, 0); tick();
    check("R2 ovc", 32'(conn_ovc[0 +: VW]), 1);
    idle(); out_credit[2*CRW +: CRW] = '0; #1;
    check("R3 other ovc no release", 32'(rel_pulse[0]), 0);
    tick();
    check("R3 other ovc still held", 32'(conn_vld[0]), 1);
    idle(); out_credit[1*CRW +: CRW] = '0; #1;
    check("R3 zero credit release", 32'(rel_pulse[0]), 1);
    tick();
    check("R3 cleared", 32'(conn_vld[0]), 0);

    // R4
    do_reset();
    sw(2, 3, 2); tick();
    idle(); ivc_empty[3*NV + 1] = 1'b1; #1;
    check("R4 other ivc no release", 32'(rel_pulse[2]), 0);
    tick();
    check("R4 other ivc still held", 32'(conn_vld[2]), 1);
    idle(); ivc_empty[3*NV + 2] = 1'b1; #1;
    check("R4 empty release", 32'(rel_pulse[2]), 1);
    tick();
    check("R4 cleared", 32'(conn_vld[2]), 0);

    // R6 with both limits
    do_reset();
    hold_limit = 4'd8;
    sw(1, 0, 0); tick();
    age_run(1, 8, 1, "R6 limit 8");
    do_reset();
    hold_limit = 4'd4;
    sw(1, 0, 0); tick();
    age_run(1, 4, 1, "R6 limit 4");

    // R7: chaining refused at the near-limit cycle
    do_reset();
    sw(0, 1, 1); tick();
    idle(); tick();
    idle(); tick();
    idle(); ch(0, 2, 3); #1;
    check("R7 near at L-1", 32'(near_starve[0]), 1);
    check("R7 no release at L-1", 32'(rel_pulse[0]), 0);
    tick();
    check("R7 chain refused input", 32'(conn_in[0 +: IW]), 1);
    check("R7 still held", 32'(conn_vld[0]), 1);
    idle(); #1;
    check("R7 release at L", 32'(rel_pulse[0]), 1);
    tick();

    // R8: restart versus continue
    do_reset();
    sw(0, 1, 0); tick();
    idle(); tick();
    idle(); ch(0, 2, 0); tick();
    check("R8 new source", 32'(conn_in[0 +: IW]), 2);
    age_run(0, 4, 1, "R8 restart");
    do_reset();
    sw(0, 1, 0); tick();
    idle(); ch(0, 1, 0); tick();
    age_run(0, 4, 2, "R8 continue");

    // R9
    do_reset();
    sw(0, 1, 0); tick();
    idle(); sw(1, 2, 0); ch(0, 2, 1); tick();
    check("R9 conflicting chain ignored", 32'(conn_in[0 +: IW]), 1);
    check("R9 other output opened", 32'(conn_in[1*IW +: IW]), 2);
    idle(); sw(2, 4, 0); ch(0, 3, 1); tick();
    check("R9 free chain accepted", 32'(conn_in[0 +: IW]), 3);

    // R10
    do_reset();
    sw(0, 1, 0); tick();
    idle(); prio_req[0] = 1'b1; sw(0, 4, 2); #1;
    check("R10 no release pulse", 32'(rel_pulse[0]), 0);
    tick();
    check("R10 new connection valid", 32'(conn_vld[0]), 1);
    check("R10 new connection input", 32'(conn_in[0 +: IW]), 4);

    // R11
    do_reset();
    starve_off = 1'b1;
    sw(3, 2, 1); tick();
    for (int k = 0; k < 12; k++) begin
      idle(); #1;
      check("R11 no near", 32'(near_starve[3]), 0);
      check("R11 no release", 32'(rel_pulse[3]), 0);
      tick();
      check("R11 held", 32'(conn_vld[3]), 1);
    end
    starve_off = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule